// File: doc/BRIEF.md
# Power-On Strap Capture and Pin Hand-Over Controller

This block owns a single pad that serves two purposes. While the chip powers up, the pad is an input. Its level, set by an external pull resistor, is read as a one-bit configuration strap. The strap picks the divide ratio of the interrupt-controller clock relative to the PCI clock. When the strap is high, that clock runs at the PCI rate. When it is low, it runs at half the PCI rate. In both cases it stays synchronous with the PCI clock.

A timer counts reference-clock cycles from the release of power-on reset. When it expires, the block does three things on the same edge:
- it freezes the strap,
- it raises a done flag,
- it enables the pad driver, so that the pad then carries the reference clock.

The length of the delay is a parameter. The default covers roughly 2 ms at the nominal 14.31818 MHz reference. The pad level passes through a two-flop synchronizer before it is captured. The captured value then holds until the next power-on reset.

Top module: `pinstrap_ctrl`

## Requirements
- R1: While `rst_n` is low, `timer_done`, `pin_oe`, `pin_out` and `strap_full_rate` are 0 and `apic_div` is 2.
- R2: `timer_done` and `pin_oe` are both first seen high after the DELAY_CYCLES-th rising edge of `clk_ref` following reset release. They are low after every earlier edge.
- R3: Once high, `timer_done` and `pin_oe` stay high until `rst_n` is asserted again.
- R4: The captured strap equals the `pin_in` level sampled at rising edge DELAY_CYCLES-2 after reset release. Levels at earlier edges, and at edge DELAY_CYCLES-1, do not affect it. Before capture, `strap_full_rate` reads 0.
- R5: After capture, changes on `pin_in` leave `strap_full_rate` and `apic_div` unchanged.
- R6: `apic_div` is the binary divide ratio of the interrupt-controller clock against the PCI clock. It is 1 when `strap_full_rate` is 1, and 2 when `strap_full_rate` is 0.
- R7: While `pin_oe` is low, `pin_out` is 0. While `pin_oe` is high, `pin_out` follows `clk_ref`.
- R8: Asserting `rst_n` after a completed hand-over returns every output to the R1 state. The following power-up captures a fresh strap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, also the clock driven onto the pad |
| rst_n | input | 1 | Power-on reset, active low |
| pin_in | input | 1 | Level seen at the shared pad |
| pin_oe | output | 1 | Pad driver enable |
| pin_out | output | 1 | Data driven onto the pad |
| strap_full_rate | output | 1 | Latched strap: 1 full PCI rate, 0 half rate |
| apic_div | output | 2 | Interrupt-controller clock divide ratio (1 or 2) |
| timer_done | output | 1 | Power-on delay has expired |

## Verification
The sweep runs every combination of three pad levels:
- the level held during reset,
- a noise level applied until shortly before expiry, followed by the level to be captured at edge DELAY_CYCLES-2,
- a different level at edge DELAY_CYCLES-1 and later, which toggles every cycle after the hand-over.

Patterns where the capture-edge level differs from its neighbours separate a correct two-stage synchronizer from one stage too many or too few. The toggling after expiry exposes a latch that keeps sampling. Each run starts from the finished state of the previous run, so every run also checks reset return and fresh capture.

// File: rtl/pinstrap_pkg.sv
// Package: shared types for the strap controller.
// Assumes: the divide ratio is encoded as a plain binary ratio value.
package pinstrap_pkg;

    typedef enum logic [1:0] {
        APIC_RATIO_FULL = 2'd1,
        APIC_RATIO_HALF = 2'd2
    } apic_ratio_e;

    // Map the latched strap level to its divide ratio.
    function automatic apic_ratio_e ratio_from_strap(input logic strap_hi);
        return strap_hi ? APIC_RATIO_FULL : APIC_RATIO_HALF;
    endfunction

endpackage

// File: rtl/pinstrap_sync.sv
// Module: multi-stage synchronizer for the pad level.
// Assumes: d may change at any time; STAGES >= 1; resets to 0.
module pinstrap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage samples the asynchronous pad level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= d;
            end
        end else begin : g_next
            // Later stages give metastability time to settle.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pinstrap_timer.sv
// Module: power-on delay counter.
// Assumes: DELAY_CYCLES >= 2. expire pulses for exactly one cycle, in the cycle
// whose closing edge sets done; done then holds until reset.
module pinstrap_timer #(
    parameter int unsigned DELAY_CYCLES = 28636
) (
    input  logic clk,
    input  logic rst_n,
    output logic expire,
    output logic done
);
    localparam int CW = $clog2(DELAY_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Expiry is detected on the final counted cycle only.
    always_comb expire = !done && (cnt == LAST);

    // Count cycles since reset release and set the sticky done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (expire) begin
            done <= 1'b1;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pinstrap_latch.sv
// Module: one-shot strap capture register and ratio decode.
// Assumes: capture pulses once per power-up; strap resets to 0 (half rate).
module pinstrap_latch
    import pinstrap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture,
    input  logic       sample,
    output logic       strap,
    output logic [1:0] ratio
);
    // Take the synchronized level once, then freeze.
    always_ff @(posedge clk) begin
        if (!rst_n)       strap <= 1'b0;
        else if (capture) strap <= sample;
    end

    // Translate the stored strap into the divide ratio.
    always_comb ratio = ratio_from_strap(strap);
endmodule

// File: rtl/pinstrap_ctrl.sv
// Module: top of the strap controller. It samples the pad as a strap during
// power-up, then hands the pad over to drive the reference clock.
// Assumes: rst_n is the power-on reset, synchronous to clk_ref.
module pinstrap_ctrl #(
    parameter int unsigned DELAY_CYCLES = 28636,
    parameter int          SYNC_STAGES  = 2
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic       pin_in,
    output logic       pin_oe,
    output logic       pin_out,
    output logic       strap_full_rate,
    output logic [1:0] apic_div,
    output logic       timer_done
);
    logic pin_sync;
    logic expire;

    pinstrap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    pinstrap_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .expire (expire),
        .done   (timer_done)
    );

    pinstrap_latch u_latch (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .capture (expire),
        .sample  (pin_sync),
        .strap   (strap_full_rate),
        .ratio   (apic_div)
    );

    // The driver enable switches on at the edge that ends the delay.
    always_ff @(posedge clk_ref) begin
        if (!rst_n)      pin_oe <= 1'b0;
        else if (expire) pin_oe <= 1'b1;
    end

    // The pad carries the reference clock only while it is driven.
    always_comb pin_out = clk_ref & pin_oe;
endmodule

// File: rtl/pinstrap_ctrl_chk.sv
// Module: assertion checker bound to pinstrap_ctrl.
// Assumes: it observes top-level ports only.
module pinstrap_ctrl_chk (
    input logic       clk_ref,
    input logic       rst_n,
    input logic       pin_oe,
    input logic       pin_out,
    input logic       strap_full_rate,
    input logic [1:0] apic_div,
    input logic       timer_done
);
    // R2: the driver enable and the done flag move together.
    a_r2_oe_tracks_done: assert property (@(posedge clk_ref) disable iff (!rst_n)
        pin_oe == timer_done);

    // R3: the done flag is sticky.
    a_r3_done_sticky: assert property (@(posedge clk_ref) disable iff (!rst_n)
        timer_done |=> timer_done);

    // R4: the strap reads 0 before capture.
    a_r4_strap_idle: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !timer_done |-> !strap_full_rate);

    // R5: the strap is frozen once captured.
    a_r5_strap_frozen: assert property (@(posedge clk_ref) disable iff (!rst_n)
        timer_done |=> $stable(strap_full_rate));

    // R6: the ratio is always a legal value.
    a_r6_ratio_legal: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (apic_div == 2'd1) || (apic_div == 2'd2));

    // R7: the pad stays quiet while undriven.
    a_r7_pad_quiet: assert property (@(negedge clk_ref) disable iff (!rst_n)
        !pin_oe |-> !pin_out);
endmodule

bind pinstrap_ctrl pinstrap_ctrl_chk u_chk (
    .clk_ref         (clk_ref),
    .rst_n           (rst_n),
    .pin_oe          (pin_oe),
    .pin_out         (pin_out),
    .strap_full_rate (strap_full_rate),
    .apic_div        (apic_div),
    .timer_done      (timer_done)
);

// File: tb/pinstrap_ctrl_bench.sv
module pinstrap_ctrl_bench;
    localparam int D = 12;

    logic       clk_ref = 1'b0;
    logic       rst_n   = 1'b0;
    logic       pin_in  = 1'b0;
    logic       pin_oe, pin_out, strap_full_rate, timer_done;
    logic [1:0] apic_div;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    pinstrap_ctrl #(.DELAY_CYCLES(D)) u_pinstrap_ctrl (
        .clk_ref         (clk_ref),
        .rst_n           (rst_n),
        .pin_in          (pin_in),
        .pin_oe          (pin_oe),
        .pin_out         (pin_out),
        .strap_full_rate (strap_full_rate),
        .apic_div        (apic_div),
        .timer_done      (timer_done)
    );

    always #5 clk_ref = ~clk_ref;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_reset_state(input string req);
        check(timer_done == 1'b0, req, int'(timer_done), 0);
        check(pin_oe == 1'b0, req, int'(pin_oe), 0);
        check(strap_full_rate == 1'b0, req, int'(strap_full_rate), 0);
        check(apic_div == 2'd2, req, int'(apic_div), 2);
        check(pin_out == 1'b0, req, int'(pin_out), 0);
    endtask

    // One power-up: pre = level during reset, early = level captured, late = level from edge D-1.
    task automatic power_up(input bit pre, input bit early, input bit late);
        @(negedge clk_ref);
        rst_n  = 1'b0;
        pin_in = pre;
        @(negedge clk_ref);
        @(negedge clk_ref);
        check_reset_state("R8");
        @(posedge clk_ref); #2;
        check(pin_out == 1'b0, "R1", int'(pin_out), 0);
        @(negedge clk_ref);
        rst_n  = 1'b1;
        pin_in = ~early;  // noise level for edge 1
        for (int n = 1; n <= D + 4; n++) begin
            bit exp_done;
            int e;
            exp_done = (n >= D);
            @(posedge clk_ref); #2;
            check(pin_out == exp_done, "R7", int'(pin_out), int'(exp_done));
            @(negedge clk_ref);
            check(timer_done == exp_done, exp_done ? "R3" : "R2", int'(timer_done), int'(exp_done));
            check(pin_oe == exp_done, "R2", int'(pin_oe), int'(exp_done));
            check(pin_out == 1'b0, "R7", int'(pin_out), 0);
            check(strap_full_rate == (exp_done ? early : 1'b0), exp_done ? "R5" : "R4",
                  int'(strap_full_rate), int'(exp_done ? early : 1'b0));
            check(apic_div == ((exp_done && early) ? 2'd1 : 2'd2), "R6",
                  int'(apic_div), (exp_done && early) ? 1 : 2);
            e = n + 1;  // next edge to sample the new level
            if (e < D - 4)       pin_in = ~early;
            else if (e <= D - 2) pin_in = early;
            else if (e <= D)     pin_in = late;
            else                 pin_in = late ^ e[0];
        end
    endtask

    initial begin
        #2;
        check_reset_state("R1");
        for (int p = 0; p < 8; p++) begin
            power_up(p[2], p[0], p[1]);
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule